// File: doc/BRIEF.md
# Programmable Bank Chip-Select Decoder

This block sits between a CPU's external-bus request and the bus sequencer. It holds six bank descriptors, each loaded through a simple write port. When an access starts, the 24-bit address is compared against every enabled bank. The lowest-numbered bank that hits gets its active-low chip select asserted. Its index, cycle type (generic or DRAM), bus width and device access time in clock cycles go to the sequencer. An address that hits nothing raises a one-cycle no-match flag and leaves every select released.

Each bank is programmed as a power-of-two window. The size is given as a log2 exponent and is clamped by the bank's cycle type. Bank 0 serves the boot device and is therefore always generic. DRAM banks together may not claim more than 32 MB. A DRAM bank that would push the running total past that limit is left out of the decode.

The decode is captured on the access-start strobe and held until the access ends or a new one starts. Register writes made while an access is held only affect later accesses.

Top module: `bank_cs_decoder`

## Requirements
- R1: After reset every bank is disabled, `csN` is all ones, `noMatch` is 0 and `selBank`, `selDram`, `selWide`, `selAcc` are 0.
- R2: A bank whose enable bit is 0 never asserts its select. An access that hits no bank leaves `csN` all ones.
- R3: An enabled bank hits when address bits at and above its effective size exponent equal the same bits of its base. Base bits below the exponent are ignored.
- R4: In generic mode (`wrDram`=0) the effective exponent is the programmed `wrSize` clamped to at most 20 (1 MB).
- R5: In DRAM mode (`wrDram`=1) the effective exponent is clamped to at most 23 (8 MB). In either mode it is raised to at least 12 (4 KB).
- R6: Writing `wrDram`=1 to bank 0 is ignored. Bank 0 always decodes as generic, with `selDram`=0 and a 1 MB clamp.
- R7: When several enabled banks hit, the lowest-numbered one is selected.
- R8: Enabled DRAM banks are taken in ascending index order. A DRAM bank whose window would push the sum of windows already accepted past 32 MB never hits.
- R9: On a hit, exactly bit `selBank` of `csN` is low. `selDram`, `selWide` and `selAcc` equal that bank's programmed mode, width bit and access-time field.
- R10: The result is captured in the cycle after `accValid` and held while neither `accValid` nor `accEnd` is high. Writes during that time do not change it, and the next access uses the new values.
- R11: `noMatch` is high for exactly the one cycle after an access strobe that hit no bank.
- R12: `accEnd` without `accValid` releases all selects (`csN` all ones) from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bank register write strobe |
| wrBank | input | 3 | Bank index written (0..5; others ignored) |
| wrOn | input | 1 | Bank enable |
| wrBase | input | 24 | Window base address |
| wrSize | input | 5 | Window size as log2 of bytes |
| wrDram | input | 1 | 1 = DRAM cycle type, 0 = generic |
| wrWide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| wrAcc | input | 4 | Device access time in clock cycles |
| accValid | input | 1 | Access start; address is decoded this cycle |
| accEnd | input | 1 | Access end; releases the selects |
| accAddr | input | 24 | CPU byte address |
| csN | output | 6 | Active-low bank selects |
| selBank | output | 3 | Index of the selected bank |
| selDram | output | 1 | Selected bank is DRAM |
| selWide | output | 1 | Selected bank bus width |
| selAcc | output | 4 | Selected bank access time |
| noMatch | output | 1 | One-cycle flag: last access hit no bank |

## Verification
The properties assume that `accValid` and `accEnd` are driven to known levels after reset. They also take the selected index to be below six, which holds only if writes never target a phantom bank index as a live one. The stimulus keeps `wrBank` within 0..5 for the random writes. It drives strobes only between clock edges, and it always separates accesses with idle or end cycles so that each held decode can be observed. Random bases and addresses are drawn near programmed windows, so both hits and misses come up often.

// File: rtl/bank_cs_pkg.sv
package bank_cs_pkg;
  localparam int DEF_BANKS   = 6;
  localparam int DEF_ADDR_W  = 24;
  localparam int DEF_SIZE_W  = 5;
  localparam int DEF_ACC_W   = 4;

  typedef struct packed {
    logic loadDecode;
    logic clearDecode;
    logic writeReg;
  } ctl_strobe_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } acc_state_t;
endpackage

// File: rtl/bank_cs_ctrl.sv
module bank_cs_ctrl
  import bank_cs_pkg::*;
#(
  parameter int NUM_BANKS = DEF_BANKS,
  parameter int IDX_W     = $clog2(NUM_BANKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrBank,
  input  logic             accValid,
  input  logic             accEnd,
  output ctl_strobe_t      strobe
);
  acc_state_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (accValid) begin
      state <= ST_ACTIVE;
    end else if (accEnd) begin
      state <= ST_IDLE;
    end
  end

  always_comb begin
    strobe.loadDecode  = accValid;
    strobe.clearDecode = accEnd && !accValid && (state == ST_ACTIVE);
    strobe.writeReg    = wrEn && (int'(wrBank) < NUM_BANKS);
  end
endmodule

// File: rtl/bank_cs_dpath.sv
module bank_cs_dpath
  import bank_cs_pkg::*;
#(
  parameter int NUM_BANKS   = DEF_BANKS,
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int SIZE_W      = DEF_SIZE_W,
  parameter int ACC_W       = DEF_ACC_W,
  parameter int GEN_MAX     = 20,
  parameter int DRAM_MAX    = 23,
  parameter int SIZE_MIN    = 12,
  parameter int DRAM_TOT_LG = 25,
  parameter int IDX_W       = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic [IDX_W-1:0]  wrBank,
  input  logic              wrOn,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic              wrDram,
  input  logic              wrWide,
  input  logic [ACC_W-1:0]  wrAcc,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [NUM_BANKS-1:0] csN,
  output logic [IDX_W-1:0]  selBank,
  output logic              selDram,
  output logic              selWide,
  output logic [ACC_W-1:0]  selAcc,
  output logic              noMatch
);
  localparam int BUD_W = DRAM_TOT_LG + 2;
  localparam logic [BUD_W-1:0] DRAM_LIMIT = BUD_W'(1) << DRAM_TOT_LG;

  logic              bankOn   [NUM_BANKS];
  logic [ADDR_W-1:0] bankBase [NUM_BANKS];
  logic [SIZE_W-1:0] bankSize [NUM_BANKS];
  logic              bankDram [NUM_BANKS];
  logic              bankWide [NUM_BANKS];
  logic [ACC_W-1:0]  bankAcc  [NUM_BANKS];

  logic [SIZE_W-1:0] effSize  [NUM_BANKS];
  logic [BUD_W-1:0]  winBytes [NUM_BANKS];
  logic [NUM_BANKS-1:0] fits;
  logic [NUM_BANKS-1:0] hit;
  logic [IDX_W-1:0]  winIdx;
  logic              anyHit;

  function automatic logic [SIZE_W-1:0] clampSize(input logic [SIZE_W-1:0] sz,
                                                  input logic dram);
    logic [SIZE_W-1:0] hiLim;
    logic [SIZE_W-1:0] res;
    hiLim = dram ? SIZE_W'(DRAM_MAX) : SIZE_W'(GEN_MAX);
    res   = (sz > hiLim) ? hiLim : sz;
    if (res < SIZE_W'(SIZE_MIN)) res = SIZE_W'(SIZE_MIN);
    return res;
  endfunction

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankOn[g]   <= 1'b0;
        bankBase[g] <= '0;
        bankSize[g] <= '0;
        bankDram[g] <= 1'b0;
        bankWide[g] <= 1'b0;
        bankAcc[g]  <= '0;
      end else if (strobe.writeReg && (wrBank == IDX_W'(g))) begin
        bankOn[g]   <= wrOn;
        bankBase[g] <= wrBase;
        bankSize[g] <= wrSize;
        bankDram[g] <= (g == 0) ? 1'b0 : wrDram;
        bankWide[g] <= wrWide;
        bankAcc[g]  <= wrAcc;
      end
    end

    logic [ADDR_W-1:0] winMask;
    always_comb begin
      effSize[g]  = clampSize(bankSize[g], bankDram[g]);
      winBytes[g] = BUD_W'(1) << effSize[g];
      winMask     = ~((ADDR_W'(1) << effSize[g]) - ADDR_W'(1));
      hit[g]      = bankOn[g] && fits[g] &&
                    (((accAddr ^ bankBase[g]) & winMask) == '0);
    end
  end

  always_comb begin
    logic [BUD_W-1:0] used;
    used = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      fits[i] = 1'b1;
      if (bankOn[i] && bankDram[i]) begin
        if (used + winBytes[i] > DRAM_LIMIT) fits[i] = 1'b0;
        else used = used + winBytes[i];
      end
    end
  end

  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        winIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN     <= '1;
      selBank <= '0;
      selDram <= 1'b0;
      selWide <= 1'b0;
      selAcc  <= '0;
      noMatch <= 1'b0;
    end else if (strobe.loadDecode) begin
      if (anyHit) begin
        csN     <= ~(NUM_BANKS'(1) << winIdx);
        selBank <= winIdx;
        selDram <= bankDram[winIdx];
        selWide <= bankWide[winIdx];
        selAcc  <= bankAcc[winIdx];
        noMatch <= 1'b0;
      end else begin
        csN     <= '1;
        selBank <= '0;
        selDram <= 1'b0;
        selWide <= 1'b0;
        selAcc  <= '0;
        noMatch <= 1'b1;
      end
    end else begin
      noMatch <= 1'b0;
      if (strobe.clearDecode) begin
        csN     <= '1;
        selBank <= '0;
        selDram <= 1'b0;
        selWide <= 1'b0;
        selAcc  <= '0;
      end
    end
  end
endmodule

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder
  import bank_cs_pkg::*;
#(
  parameter int NUM_BANKS = DEF_BANKS,
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int SIZE_W    = DEF_SIZE_W,
  parameter int ACC_W     = DEF_ACC_W,
  parameter int IDX_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrBank,
  input  logic                 wrOn,
  input  logic [ADDR_W-1:0]    wrBase,
  input  logic [SIZE_W-1:0]    wrSize,
  input  logic                 wrDram,
  input  logic                 wrWide,
  input  logic [ACC_W-1:0]     wrAcc,
  input  logic                 accValid,
  input  logic                 accEnd,
  input  logic [ADDR_W-1:0]    accAddr,
  output logic [NUM_BANKS-1:0] csN,
  output logic [IDX_W-1:0]     selBank,
  output logic                 selDram,
  output logic                 selWide,
  output logic [ACC_W-1:0]     selAcc,
  output logic                 noMatch
);
  ctl_strobe_t strobe;

  bank_cs_ctrl #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBank(wrBank),
    .accValid(accValid), .accEnd(accEnd), .strobe(strobe)
  );

  bank_cs_dpath #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .ACC_W(ACC_W), .IDX_W(IDX_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrBank(wrBank),
    .wrOn(wrOn), .wrBase(wrBase), .wrSize(wrSize), .wrDram(wrDram),
    .wrWide(wrWide), .wrAcc(wrAcc), .accAddr(accAddr),
    .csN(csN), .selBank(selBank), .selDram(selDram), .selWide(selWide),
    .selAcc(selAcc), .noMatch(noMatch)
  );
endmodule

// File: rtl/bank_cs_checker.sv
module bank_cs_checker #(
  parameter int NUM_BANKS = 6,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 accValid,
  input logic                 accEnd,
  input logic [NUM_BANKS-1:0] csN,
  input logic [IDX_W-1:0]     selBank,
  input logic                 selDram,
  input logic                 noMatch
);
  p_one_select_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  p_sel_index_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(&csN) |-> (csN == ~(NUM_BANKS'(1) << selBank)));

  p_nomatch_released_r2: assert property (@(posedge clk) disable iff (!rstN)
    noMatch |-> (&csN));

  p_bank0_generic_r6: assert property (@(posedge clk) disable iff (!rstN)
    !csN[0] |-> !selDram);

  p_nomatch_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    (noMatch && !accValid) |=> !noMatch);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!accValid && !accEnd) |=> $stable(csN));

  p_release_r12: assert property (@(posedge clk) disable iff (!rstN)
    (accEnd && !accValid) |=> (&csN));
endmodule

bind bank_cs_decoder bank_cs_checker #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accEnd(accEnd),
  .csN(csN), .selBank(selBank), .selDram(selDram), .noMatch(noMatch)
);

// File: tb/bank_cs_decoder_tb.sv
module bank_cs_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrBank = '0;
  logic        wrOn = 1'b0;
  logic [23:0] wrBase = '0;
  logic [4:0]  wrSize = '0;
  logic        wrDram = 1'b0;
  logic        wrWide = 1'b0;
  logic [3:0]  wrAcc = '0;
  logic        accValid = 1'b0;
  logic        accEnd = 1'b0;
  logic [23:0] accAddr = '0;
  logic [5:0]  csN;
  logic [2:0]  selBank;
  logic        selDram;
  logic        selWide;
  logic [3:0]  selAcc;
  logic        noMatch;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic        mOn   [6];
  logic [23:0] mBase [6];
  logic [4:0]  mSize [6];
  logic        mDram [6];
  logic        mWide [6];
  logic [3:0]  mAcc  [6];

  bank_cs_decoder u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBank(wrBank), .wrOn(wrOn),
    .wrBase(wrBase), .wrSize(wrSize), .wrDram(wrDram), .wrWide(wrWide),
    .wrAcc(wrAcc), .accValid(accValid), .accEnd(accEnd), .accAddr(accAddr),
    .csN(csN), .selBank(selBank), .selDram(selDram), .selWide(selWide),
    .selAcc(selAcc), .noMatch(noMatch)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int effOf(input int i);
    int e;
    e = int'(mSize[i]);
    if (mDram[i] && e > 23) e = 23;
    if (!mDram[i] && e > 20) e = 20;
    if (e < 12) e = 12;
    return e;
  endfunction

  function automatic int expIdx(input logic [23:0] a);
    longint used = 0;
    int res = -1;
    for (int i = 0; i < 6; i++) begin
      int e;
      bit ok;
      e = effOf(i);
      ok = mOn[i];
      if (mOn[i] && mDram[i]) begin
        if (used + (longint'(1) << e) > (longint'(1) << 25)) ok = 0;
        else used += longint'(1) << e;
      end
      if (ok && res < 0 && ((a >> e) == (mBase[i] >> e))) res = i;
    end
    return res;
  endfunction

  task automatic writeBank(input int i, input bit on, input logic [23:0] base,
                           input logic [4:0] sz, input bit dram, input bit wide,
                           input logic [3:0] acc);
    @(negedge clk);
    wrEn = 1'b1; wrBank = 3'(i); wrOn = on; wrBase = base; wrSize = sz;
    wrDram = dram; wrWide = wide; wrAcc = acc;
    @(negedge clk);
    wrEn = 1'b0;
    mOn[i] = on; mBase[i] = base; mSize[i] = sz;
    mDram[i] = (i == 0) ? 1'b0 : dram;
    mWide[i] = wide; mAcc[i] = acc;
  endtask

  task automatic accessChk(input logic [23:0] a, input string req);
    int e;
    e = expIdx(a);
    @(negedge clk);
    accValid = 1'b1; accAddr = a;
    @(negedge clk);
    accValid = 1'b0;
    if (e < 0) begin
      chk(csN == 6'h3F && noMatch, req, {csN, noMatch}, {6'h3F, 1'b1});
    end else begin
      chk(csN == ~(6'd1 << e) && !noMatch, req, csN, ~(6'd1 << e) & 6'h3F);
      chk(selBank == 3'(e) && selDram == mDram[e] && selWide == mWide[e] && selAcc == mAcc[e],
          {req, "/R9 fields"}, {selBank, selDram, selWide, selAcc},
          {3'(e), mDram[e], mWide[e], mAcc[e]});
    end
  endtask

  task automatic endAccess();
    @(negedge clk);
    accEnd = 1'b1;
    @(negedge clk);
    accEnd = 1'b0;
    chk(csN == 6'h3F, "R12 release", csN, 6'h3F);
  endtask

  task automatic clearAll();
    for (int i = 0; i < 6; i++) writeBank(i, 0, 24'h0, 5'd12, 0, 0, 4'h0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      mOn[i] = 0; mBase[i] = 0; mSize[i] = 0; mDram[i] = 0; mWide[i] = 0; mAcc[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(csN == 6'h3F && !noMatch && selBank == 0 && !selDram && !selWide && selAcc == 0,
        "R1 reset", {csN, noMatch, selBank, selAcc}, {6'h3F, 1'b0, 3'd0, 4'd0});

    // R2 disabled banks never hit; R11 pulse length
    writeBank(2, 0, 24'h340000, 5'd16, 0, 1, 4'h3);
    accessChk(24'h340010, "R2 disabled");
    @(negedge clk);
    chk(!noMatch, "R11 pulse one cycle", noMatch, 0);

    // R3 compare above size, low base bits ignored
    writeBank(2, 1, 24'h34FFFF, 5'd16, 0, 1, 4'h3);
    accessChk(24'h340001, "R3 hit low bits ignored");
    accessChk(24'h350000, "R3 miss next window");

    // R4 generic clamp to 1 MB
    writeBank(1, 1, 24'h800000, 5'd23, 0, 0, 4'h7);
    accessChk(24'h8FFFFF, "R4 inside 1MB");
    accessChk(24'h900000, "R4 beyond 1MB");

    // R5 DRAM clamp to 8 MB and 4 KB minimum
    clearAll();
    writeBank(3, 1, 24'h000000, 5'd25, 1, 1, 4'h2);
    accessChk(24'h7FFFFF, "R5 DRAM 8MB inside");
    accessChk(24'h800000, "R5 DRAM 8MB outside");
    writeBank(4, 1, 24'hA00000, 5'd0, 0, 0, 4'h1);
    accessChk(24'hA00FFF, "R5 minimum 4KB inside");
    accessChk(24'hA01000, "R5 minimum 4KB outside");

    // R6 bank 0 stays generic
    clearAll();
    writeBank(0, 1, 24'h000000, 5'd23, 1, 1, 4'h5);
    accessChk(24'h0FFFFF, "R6 bank0 generic");
    chk(!selDram, "R6 selDram", selDram, 0);
    accessChk(24'h100000, "R6 bank0 1MB clamp");

    // R7 lowest index wins
    writeBank(4, 1, 24'h200000, 5'd20, 1, 0, 4'h9);
    writeBank(1, 1, 24'h200000, 5'd16, 0, 1, 4'h4);
    accessChk(24'h200100, "R7 priority");
    chk(selBank == 3'd1, "R7 bank1", selBank, 1);

    // R8 DRAM budget
    clearAll();
    for (int i = 1; i <= 4; i++) writeBank(i, 1, 24'h000000, 5'd23, 1, 0, 4'h2);
    writeBank(5, 1, 24'h800000, 5'd12, 1, 1, 4'h6);
    accessChk(24'h800010, "R8 over budget");
    chk(noMatch, "R8 noMatch", noMatch, 1);
    writeBank(4, 1, 24'h000000, 5'd22, 1, 0, 4'h2);
    accessChk(24'h800010, "R8 fits again");
    chk(csN == 6'h1F, "R8 bank5 selected", csN, 6'h1F);

    // R10 hold against writes, new values on next access
    clearAll();
    writeBank(2, 1, 24'h400000, 5'd20, 0, 1, 4'hA);
    accessChk(24'h400020, "R10 initial");
    writeBank(2, 0, 24'h400000, 5'd20, 0, 1, 4'hA);
    repeat (3) @(negedge clk);
    chk(csN == 6'h3B && selAcc == 4'hA, "R10 hold", {csN, selAcc}, {6'h3B, 4'hA});
    accessChk(24'h400020, "R10 next access uses write");
    endAccess();

    // Random phase
    clearAll();
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 2) == 0 || n < 6) begin
        int b;
        logic [23:0] base;
        b = $urandom_range(0, 5);
        base = 24'($urandom) & 24'hF00000 | 24'($urandom_range(0, 15) << 16);
        writeBank(b, $urandom_range(0, 3) != 0, base, 5'($urandom_range(8, 26)),
                  $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 4'($urandom));
      end else begin
        int b;
        logic [23:0] a;
        b = $urandom_range(0, 5);
        a = mBase[b] ^ 24'($urandom_range(0, 1) ? ($urandom & 32'hFFFF) : $urandom);
        accessChk(a, "R9 random");
        if ($urandom_range(0, 1) == 1) endAccess();
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule